// File: doc/BRIEF.md
# Sync-Gated Serial Receive Buffer

This block gathers recovered receive bits, each marked by a one-cycle strobe, into a 16-bit store and tells a host when enough of them have arrived. A control input selects between two ways of filling. With gating off, every strobed bit is kept. With gating on, a detector watches the incoming stream for the fixed 16-bit sync word 2DD4h. Bits are kept only after that word has been seen, and a valid-data output announces the lock.

A fill flag rises once the number of stored bits reaches a programmable threshold. It stays high until the host has pulled the final stored bit. The host reads the store one bit at a time: it holds the read select high and raises a read clock, and the oldest stored bit appears on the serial output one system clock later. Bits that arrive while the store is full are discarded, and an overflow flag records the loss.

The detector has three named states. PASS is entered whenever gating is off. The PASS→HUNT transition is taken when gating is turned on. The HUNT→LOCK transition is taken when a strobe completes the sync word. The LOCK→PASS and HUNT→PASS transitions are taken when gating is turned off. Reset enters PASS.

Top module: `sync_rx_fifo`

## Requirements
- R1: After reset, the serial read output, the fill flag, the valid-data flag and the overflow flag are all 0, and the store is empty.
- R2: With sync_en low, every strobed bit is stored, and reads return the stored bits oldest first.
- R3: With sync_en high, no bit is stored until the last 16 strobed bits equal 2DD4h. The earliest of those 16 bits is the most significant bit of 2DD4h. The bits of the matched word are not stored; only bits strobed after the match are stored.
- R4: valid_data rises in the cycle after the strobe that completes the sync word, and stays high while sync_en stays high.
- R5: Lowering sync_en drops valid_data on the next clock and re-arms the detector. After sync_en is raised again, bits are discarded until a fresh full sync word is seen.
- R6: fill rises on the store that makes the stored-bit count equal to thresh, for thresh values 1 to 15. A thresh of 0 never raises fill.
- R7: Once high, fill stays high until the read that removes the last stored bit; it is low in the cycle after that read.
- R8: A rising edge of rd_clk sampled while rd_sel is high removes the oldest bit and places it on rd_data one clock later. rd_clk edges while rd_sel is low change neither rd_data nor the stored contents.
- R9: The store holds at most 16 bits. A bit strobed while the store is full and no read is taking place is discarded and sets overflow. overflow clears when the store is read down to empty.
- R10: A read of an empty store drives rd_data to 0 and changes nothing else.
- R11: A store and a read in the same cycle both take effect: the read returns the oldest bit and the new bit joins the end of the queue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_in | input | 1 | Recovered receive data bit |
| bit_stb | input | 1 | One-cycle strobe qualifying bit_in |
| sync_en | input | 1 | High: store only after the sync word is seen |
| thresh | input | 4 | Stored-bit count that raises fill (0 disables) |
| rd_sel | input | 1 | Read select for the serial read port |
| rd_clk | input | 1 | Read clock from the host, edge-detected in the clk domain |
| rd_data | output | 1 | Serial read data, oldest bit first |
| fill | output | 1 | Threshold reached, held until the store is drained |
| valid_data | output | 1 | Sync word seen while gating is on |
| overflow | output | 1 | A bit was lost because the store was full |

## Verification
A detector stuck in HUNT or falsely in LOCK shows at valid_data one clock after the deciding strobe. It also shows in the bit count the host later reads out. A wrong stored-bit count shows at fill on the store that should reach the threshold, and again on the read that should drain the store, because fill must then fall in the very next cycle. Corrupted ordering or a bad write position in the store shows only when the bits are read back, so every scenario drains the store completely and compares each bit in order.

// File: rtl/sfifo_pkg.sv
package sfifo_pkg;

    // Fixed pattern the detector hunts for; earliest received bit is the MSB.
    localparam int            SYNC_W    = 16;
    localparam logic [15:0]   SYNC_WORD = 16'h2DD4;

    typedef enum logic [1:0] {
        ST_PASS = 2'd0,   // gating off, every strobed bit is stored
        ST_HUNT = 2'd1,   // gating on, looking for the sync word
        ST_LOCK = 2'd2    // sync word seen, bits are stored
    } hunt_state_e;

endpackage

// File: rtl/sync_hunter.sv
module sync_hunter
    import sfifo_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sync_en,
    input  logic bit_in,
    input  logic bit_stb,
    output logic store_req,
    output logic valid_o
);

    hunt_state_e            state_q, state_d;
    logic [SYNC_W-1:0]      win_q, win_d;
    logic [SYNC_W-1:0]      win_next;
    logic                   hit;

    assign win_next = {win_q[SYNC_W-2:0], bit_in};
    assign hit      = sync_en && bit_stb && (state_q != ST_LOCK) && (win_next == SYNC_WORD);

    // Next state and sliding window
    always_comb begin
        state_d = state_q;
        win_d   = win_q;
        unique case (state_q)
            ST_PASS: begin
                win_d = '0;
                if (sync_en) begin
                    state_d = ST_HUNT;
                    if (bit_stb) win_d = win_next;
                end
            end
            ST_HUNT: begin
                if (!sync_en) begin
                    state_d = ST_PASS;
                    win_d   = '0;
                end else if (hit) begin
                    state_d = ST_LOCK;
                    win_d   = '0;
                end else if (bit_stb) begin
                    win_d = win_next;
                end
            end
            ST_LOCK: begin
                win_d = '0;
                if (!sync_en) state_d = ST_PASS;
            end
            default: begin
                state_d = ST_PASS;
                win_d   = '0;
            end
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_PASS;
            win_q   <= '0;
        end else begin
            state_q <= state_d;
            win_q   <= win_d;
        end
    end

    // Outputs
    always_comb begin
        valid_o   = 1'b0;
        store_req = 1'b0;
        unique case (state_q)
            ST_PASS: store_req = bit_stb && !sync_en;
            ST_HUNT: store_req = bit_stb && !sync_en;
            ST_LOCK: begin
                valid_o   = 1'b1;
                store_req = bit_stb;
            end
            default: begin
                valid_o   = 1'b0;
                store_req = 1'b0;
            end
        endcase
    end

    AST_VALID_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        !sync_en |=> !valid_o);   // R5

    AST_VALID_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(valid_o) |-> ($past(bit_stb) && $past(sync_en)));   // R4

endmodule

// File: rtl/bit_store.sv
module bit_store #(
    parameter int DEPTH = 16,
    parameter int TW    = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_req,
    input  logic          wr_bit,
    input  logic          pop_req,
    input  logic [TW-1:0] thresh,
    output logic          head_bit,
    output logic          empty,
    output logic          fill,
    output logic          ovf
);

    localparam int CW = $clog2(DEPTH + 1);

    logic [DEPTH-1:0] buf_q, buf_d;
    logic [CW-1:0]    cnt_q, cnt_d, wpos;
    logic             fill_q, fill_d;
    logic             ovf_q, ovf_d;
    logic             pop_ok, wr_ok, full;

    assign full     = (cnt_q == CW'(DEPTH));
    assign empty    = (cnt_q == '0);
    assign head_bit = buf_q[0];
    assign pop_ok   = pop_req && !empty;
    assign wr_ok    = wr_req && (!full || pop_ok);

    always_comb begin
        buf_d = pop_ok ? (buf_q >> 1) : buf_q;
        wpos  = pop_ok ? (cnt_q - CW'(1)) : cnt_q;
        if (wr_ok) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (wpos == CW'(i)) buf_d[i] = wr_bit;
            end
        end
        cnt_d = cnt_q - CW'(pop_ok) + CW'(wr_ok);

        fill_d = fill_q;
        if (wr_ok && (thresh != '0) && (cnt_d == CW'(thresh)))
            fill_d = 1'b1;
        else if (pop_ok && (cnt_d == '0))
            fill_d = 1'b0;

        ovf_d = ovf_q;
        if (wr_req && !wr_ok)
            ovf_d = 1'b1;
        else if (pop_ok && (cnt_d == '0))
            ovf_d = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            buf_q  <= '0;
            cnt_q  <= '0;
            fill_q <= 1'b0;
            ovf_q  <= 1'b0;
        end else begin
            buf_q  <= buf_d;
            cnt_q  <= cnt_d;
            fill_q <= fill_d;
            ovf_q  <= ovf_d;
        end
    end

    assign fill = fill_q;
    assign ovf  = ovf_q;

    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(DEPTH));   // R9

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (full && wr_req && !pop_req) |=> (cnt_q == CW'(DEPTH) && ovf_q));   // R9

    AST_FILL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fill_q) |-> (cnt_q == '0));   // R7

    AST_EMPTY_POP_NOCHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && pop_req && !wr_req) |=> (cnt_q == '0));   // R10

endmodule

// File: rtl/read_port.sv
module read_port (
    input  logic clk,
    input  logic rst_n,
    input  logic rd_sel,
    input  logic rd_clk,
    input  logic head_bit,
    input  logic empty,
    output logic pop_req,
    output logic rd_data
);

    logic rck_q;
    logic rd_q;

    assign pop_req = rd_sel && rd_clk && !rck_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rck_q <= 1'b0;
            rd_q  <= 1'b0;
        end else begin
            rck_q <= rd_clk;
            if (pop_req) rd_q <= empty ? 1'b0 : head_bit;
        end
    end

    assign rd_data = rd_q;

    AST_READ_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_sel |=> $stable(rd_data));   // R8

endmodule

// File: rtl/sync_rx_fifo.sv
module sync_rx_fifo #(
    parameter int DEPTH = 16,
    parameter int TW    = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bit_in,
    input  logic          bit_stb,
    input  logic          sync_en,
    input  logic [TW-1:0] thresh,
    input  logic          rd_sel,
    input  logic          rd_clk,
    output logic          rd_data,
    output logic          fill,
    output logic          valid_data,
    output logic          overflow
);

    logic store_req;
    logic pop_req;
    logic head_bit;
    logic empty;

    sync_hunter u_hunt (
        .clk       (clk),
        .rst_n     (rst_n),
        .sync_en   (sync_en),
        .bit_in    (bit_in),
        .bit_stb   (bit_stb),
        .store_req (store_req),
        .valid_o   (valid_data)
    );

    bit_store #(.DEPTH(DEPTH), .TW(TW)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_req   (store_req),
        .wr_bit   (bit_in),
        .pop_req  (pop_req),
        .thresh   (thresh),
        .head_bit (head_bit),
        .empty    (empty),
        .fill     (fill),
        .ovf      (overflow)
    );

    read_port u_rd (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_sel   (rd_sel),
        .rd_clk   (rd_clk),
        .head_bit (head_bit),
        .empty    (empty),
        .pop_req  (pop_req),
        .rd_data  (rd_data)
    );

    AST_STORE_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        store_req |-> bit_stb);   // R2

endmodule

// File: tb/tb_sync_rx_fifo.sv
module tb_sync_rx_fifo;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_in = 1'b0;
    logic       bit_stb = 1'b0;
    logic       sync_en = 1'b0;
    logic [3:0] thresh = 4'd0;
    logic       rd_sel = 1'b0;
    logic       rd_clk = 1'b0;
    logic       rd_data, fill, valid_data, overflow;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    sync_rx_fifo dut (
        .clk(clk), .rst_n(rst_n), .bit_in(bit_in), .bit_stb(bit_stb),
        .sync_en(sync_en), .thresh(thresh), .rd_sel(rd_sel), .rd_clk(rd_clk),
        .rd_data(rd_data), .fill(fill), .valid_data(valid_data), .overflow(overflow)
    );

    typedef struct packed {
        logic        sync;
        logic [3:0]  thr;
        logic [5:0]  len;
        logic [31:0] stream;
        logic        exp_valid;
        logic        exp_fill;
        logic [4:0]  exp_cnt;
        logic [15:0] exp_data;
    } vec_t;

    // stream is sent MSB first; exp_data holds the stored bits, oldest as MSB of exp_cnt bits
    localparam vec_t VEC [6] = '{
        '{1'b0, 4'd4, 6'd8,  32'h0000_00B2, 1'b0, 1'b1, 5'd8, 16'h00B2},
        '{1'b0, 4'd9, 6'd6,  32'h0000_002D, 1'b0, 1'b0, 5'd6, 16'h002D},
        '{1'b1, 4'd3, 6'd20, 32'h0002_DD4C, 1'b1, 1'b1, 5'd4, 16'h000C},
        '{1'b1, 4'd2, 6'd23, 32'h0001_6EA5, 1'b1, 1'b1, 5'd3, 16'h0005},
        '{1'b1, 4'd1, 6'd16, 32'h0000_2DD5, 1'b0, 1'b0, 5'd0, 16'h0000},
        '{1'b0, 4'd0, 6'd5,  32'h0000_001F, 1'b0, 1'b0, 5'd5, 16'h001F}
    };

    task automatic check(input logic ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; bit_stb = 1'b0; rd_clk = 1'b0; rd_sel = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic send_bit(input logic b);
        @(negedge clk);
        bit_in = b; bit_stb = 1'b1;
        @(negedge clk);
        bit_stb = 1'b0;
    endtask

    task automatic read_bit(output logic b);
        @(negedge clk);
        rd_sel = 1'b1; rd_clk = 1'b1;
        @(negedge clk);
        b = rd_data;
        rd_clk = 1'b0;
        @(negedge clk);
    endtask

    logic got;

    initial begin
        // Vector table
        for (int v = 0; v < 6; v++) begin
            sync_en = VEC[v].sync;
            thresh  = VEC[v].thr;
            do_reset();
            for (int i = 0; i < int'(VEC[v].len); i++)
                send_bit(VEC[v].stream[int'(VEC[v].len) - 1 - i]);
            @(negedge clk);
            check(valid_data == VEC[v].exp_valid, "R3/R4 valid_data after stream", int'(valid_data), int'(VEC[v].exp_valid));
            check(fill == VEC[v].exp_fill, "R6 fill after stream", int'(fill), int'(VEC[v].exp_fill));
            for (int i = 0; i < int'(VEC[v].exp_cnt); i++) begin
                read_bit(got);
                check(got == VEC[v].exp_data[int'(VEC[v].exp_cnt) - 1 - i], "R2/R3 read order", int'(got),
                      int'(VEC[v].exp_data[int'(VEC[v].exp_cnt) - 1 - i]));
                if (VEC[v].exp_fill && (i < int'(VEC[v].exp_cnt) - 1))
                    check(fill == 1'b1, "R7 fill held before last read", int'(fill), 1);
            end
            check(fill == 1'b0, "R7 fill low after drain", int'(fill), 0);
            read_bit(got);
            check(got == 1'b0, "R10 empty read gives 0", int'(got), 0);
            check(overflow == 1'b0, "R9 no overflow", int'(overflow), 0);
        end

        // R1: reset state after activity
        sync_en = 1'b0; thresh = 4'd1;
        do_reset();
        send_bit(1'b1);
        do_reset();
        @(negedge clk);
        check({rd_data, fill, valid_data, overflow} == 4'b0, "R1 outputs after reset",
              int'({rd_data, fill, valid_data, overflow}), 0);
        read_bit(got);
        check(got == 1'b0, "R1 store empty after reset", int'(got), 0);

        // R9: overflow and drain
        sync_en = 1'b0; thresh = 4'd15;
        do_reset();
        for (int i = 0; i < 15; i++) send_bit(1'(16'hA5C3 >> (15 - i)));
        check(fill == 1'b1, "R6 fill at 15 bits", int'(fill), 1);
        send_bit(1'b1);
        check(overflow == 1'b0, "R9 sixteenth bit fits", int'(overflow), 0);
        send_bit(1'b0);
        send_bit(1'b0);
        check(overflow == 1'b1, "R9 overflow set", int'(overflow), 1);
        for (int i = 0; i < 16; i++) begin
            read_bit(got);
            check(got == 1'(16'hA5C3 >> (15 - i)), "R9 kept bits intact", int'(got), int'(1'(16'hA5C3 >> (15 - i))));
        end
        check(overflow == 1'b0, "R9 overflow cleared on drain", int'(overflow), 0);

        // R8: rd_clk without rd_sel has no effect
        do_reset();
        send_bit(1'b1);
        send_bit(1'b0);
        read_bit(got);
        check(got == 1'b1, "R8 first read", int'(got), 1);
        send_bit(1'b1);
        @(negedge clk); rd_sel = 1'b0; rd_clk = 1'b1;
        @(negedge clk); rd_clk = 1'b0;
        @(negedge clk);
        check(rd_data == 1'b1, "R8 unselected rd_clk holds rd_data", int'(rd_data), 1);
        read_bit(got);
        check(got == 1'b0, "R8 unselected rd_clk popped nothing", int'(got), 0);
        read_bit(got);
        check(got == 1'b1, "R8 last bit", int'(got), 1);

        // R5: dropping sync_en clears valid and re-arms
        sync_en = 1'b1; thresh = 4'd1;
        do_reset();
        for (int i = 0; i < 16; i++) send_bit(1'(16'h2DD4 >> (15 - i)));
        check(valid_data == 1'b1, "R4 valid after sync word", int'(valid_data), 1);
        @(negedge clk); sync_en = 1'b0;
        @(negedge clk);
        check(valid_data == 1'b0, "R5 valid drops", int'(valid_data), 0);
        sync_en = 1'b1;
        send_bit(1'b1);
        send_bit(1'b1);
        check(valid_data == 1'b0, "R5 re-armed, still hunting", int'(valid_data), 0);
        read_bit(got);
        check(got == 1'b0, "R5 bits discarded while hunting", int'(got), 0);
        check(fill == 1'b0, "R5 nothing stored", int'(fill), 0);

        // R11: simultaneous store and read
        sync_en = 1'b0; thresh = 4'd0;
        do_reset();
        send_bit(1'b1);
        send_bit(1'b0);
        @(negedge clk);
        bit_in = 1'b1; bit_stb = 1'b1; rd_sel = 1'b1; rd_clk = 1'b1;
        @(negedge clk);
        got = rd_data;
        bit_stb = 1'b0; rd_clk = 1'b0;
        check(got == 1'b1, "R11 read during store returns oldest", int'(got), 1);
        read_bit(got);
        check(got == 1'b0, "R11 second bit", int'(got), 0);
        read_bit(got);
        check(got == 1'b1, "R11 newly stored bit", int'(got), 1);
        read_bit(got);
        check(got == 1'b0, "R11 empty afterwards", int'(got), 0);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule